// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. Three input lines carry the stream: a bit clock, a channel select and one data line. The left and right words share the data line in turn, and the channel select level shows which channel is on the line. The receiver samples all three lines with its own system clock. That clock must be well above the bit clock. The receiver finds the rising edges of the bit clock and builds one word per channel period.

A 3-bit format code picks one of five framings. Two framings are left-aligned: words start at a channel-select change, or one bit after it. The other three are right-aligned with lengths of 16, 18 or 20 bits, and the word ends on the last bit before the next change. Every word leaves as a 20-bit value with a channel tag, on a valid/ready output stream. The serial input cannot be held back. When a word finishes while an earlier word is still waiting for ready, the newer word replaces the waiting one. A waiting word stays on the port, unchanged, until the consumer takes it or a newer word replaces it.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset, pcm_valid is 0, pcm_right is 0 and pcm_data is 0.
- R2: With frame_fmt = 4 (left-aligned, no delay), the bit sampled at the first rising bit-clock edge after a chan_sel change is the MSB at pcm_data[19]. A word shorter than 20 bits is filled with zeros at the LSB end. Bits after the 20th are dropped.
- R3: With frame_fmt = 0 (left-aligned, one-bit delay), the MSB is the bit at the second rising edge after a chan_sel change. Padding and truncation work as in R2.
- R4: With frame_fmt = 1, 2 or 3, the word is the last 16, 18 or 20 bits before the next chan_sel change, and the bit just before the change is the LSB. The word is sign-extended to 20 bits, and earlier bits in the period are ignored.
- R5: Data is sampled on rising bit-clock edges. chan_sel low marks a left word (pcm_right = 0) and high marks a right word (pcm_right = 1). Each word is issued once, after its period ends, in arrival order.
- R6: No word is issued for a period that began before reset was released. No word is issued for a period that began before the last change of frame_fmt. The first two rising edges after reset only set up the channel history.
- R7: With frame_fmt = 5, 6 or 7, no new word is issued, and pcm_data and pcm_right keep their values.
- R8: While pcm_valid is 1 and pcm_ready is 0, pcm_valid stays 1 and pcm_data stays stable until a newer word replaces the waiting one. The newest word is the one kept.
- R9: If a new word completes in the same cycle the consumer accepts the waiting word, pcm_valid stays 1 and the new word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock, sampled as data |
| chan_sel | input | 1 | Channel select: low left, high right |
| ser_data | input | 1 | Serial sample data |
| frame_fmt | input | 3 | Framing code: 0 delayed left-aligned, 1/2/3 right-aligned 16/18/20, 4 left-aligned |
| pcm_data | output | 20 | Received sample, MSB-aligned or sign-extended |
| pcm_right | output | 1 | Channel tag of pcm_data |
| pcm_valid | output | 1 | A sample is waiting |
| pcm_ready | input | 1 | Consumer takes the waiting sample |

## Verification
Two events can land in the same system-clock cycle: a finished word being loaded into the output slot, and the consumer accepting the word already waiting there. The bench holds ready low through a whole frame so the left word waits. It then raises ready for exactly one cycle, the cycle in which the right word is loaded, counted from the rising bit-clock edge that closes the right period. The test passes only if the left word is accepted and the right word then stays valid and arrives later, so that both words come out in order.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [2:0] {
    FMT_DLY   = 3'd0,
    FMT_RJ_S  = 3'd1,
    FMT_RJ_M  = 3'd2,
    FMT_RJ_L  = 3'd3,
    FMT_LEFT  = 3'd4
  } fmt_e;

  function automatic logic fmt_right_aligned(input logic [2:0] f);
    return (f == FMT_RJ_S) || (f == FMT_RJ_M) || (f == FMT_RJ_L);
  endfunction

  function automatic logic fmt_legal(input logic [2:0] f);
    return f <= FMT_LEFT;
  endfunction

endpackage

// File: rtl/aud_rx_tap.sv
module aud_rx_tap #(
  parameter int SYNC_DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  input  logic chan_sel,
  input  logic ser_data,
  output logic rise,
  output logic ws,
  output logic sd
);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [2:0] pipe [SYNC_DEPTH];
  logic       clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_DEPTH; i++) pipe[i] <= '0;
      clk_q <= 1'b0;
    end else begin
      pipe[0] <= {bit_clk, chan_sel, ser_data};
      for (int i = 1; i < SYNC_DEPTH; i++) pipe[i] <= pipe[i-1];
      clk_q <= pipe[LAST][2];
    end
  end

  assign rise = pipe[LAST][2] & ~clk_q;
  assign ws   = pipe[LAST][1];
  assign sd   = pipe[LAST][0];

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt,
  input  logic                rise,
  input  logic                ws,
  input  logic                sd,
  output logic                done,
  output logic [SAMPLE_W-1:0] word,
  output logic                word_right
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic [2:0]          fmt_q;
  logic                ws_d1, ws_d2;
  logic [1:0]          prime;
  logic                in_word;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] acc;
  logic [SAMPLE_W-1:0] sh;

  logic eff_ws, eff_prev, boundary, rj_mode;
  int   rj_len;

  function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] v, input int n);
    logic [SAMPLE_W-1:0] r;
    for (int i = 0; i < SAMPLE_W; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  always_comb begin
    eff_ws   = (fmt_q == FMT_DLY) ? ws_d1 : ws;
    eff_prev = (fmt_q == FMT_DLY) ? ws_d2 : ws_d1;
    boundary = (prime == 2'd2) && (eff_ws != eff_prev);
    rj_mode  = fmt_right_aligned(fmt_q);
    case (fmt_q)
      FMT_RJ_S: rj_len = SAMPLE_W - 4;
      FMT_RJ_M: rj_len = SAMPLE_W - 2;
      default:  rj_len = SAMPLE_W;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q      <= '0;
      ws_d1      <= 1'b0;
      ws_d2      <= 1'b0;
      prime      <= '0;
      in_word    <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      sh         <= '0;
      done       <= 1'b0;
      word       <= '0;
      word_right <= 1'b0;
    end else begin
      done  <= 1'b0;
      fmt_q <= fmt;
      if (rise) begin
        ws_d1 <= ws;
        ws_d2 <= ws_d1;
        if (prime != 2'd2) prime <= prime + 2'd1;
        sh <= {sh[SAMPLE_W-2:0], sd};
        if (boundary) begin
          in_word <= 1'b1;
          if (in_word && fmt_legal(fmt_q)) begin
            done       <= 1'b1;
            word       <= rj_mode ? sext(sh, rj_len) : acc;
            word_right <= eff_prev;
          end
          acc <= {sd, {(SAMPLE_W-1){1'b0}}};
          cnt <= CNT_W'(1);
        end else if (cnt < CNT_W'(SAMPLE_W)) begin
          acc[CNT_W'(SAMPLE_W-1) - cnt] <= sd;
          cnt <= cnt + CNT_W'(1);
        end
      end
      if (fmt != fmt_q) in_word <= 1'b0;
    end
  end

  // R5: bit clock slower than system clock gives one strobe per word
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: reserved codes never produce a word
  assert_no_word_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fmt_q) <= 3'd4));

  // R4: the shortest right-aligned word is sign-extended over the top bits
  assert_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(fmt_q) == FMT_RJ_S)) |->
      ((word[SAMPLE_W-1 -: 5] == '0) || (word[SAMPLE_W-1 -: 5] == '1)));

endmodule

// File: rtl/aud_rx_slot.sv
module aud_rx_slot #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] load_data,
  input  logic                load_right,
  output logic [SAMPLE_W-1:0] pcm_data,
  output logic                pcm_right,
  output logic                pcm_valid,
  input  logic                pcm_ready
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_data  <= '0;
      pcm_right <= 1'b0;
      pcm_valid <= 1'b0;
    end else if (load) begin
      pcm_data  <= load_data;
      pcm_right <= load_right;
      pcm_valid <= 1'b1;
    end else if (pcm_ready) begin
      pcm_valid <= 1'b0;
    end
  end

  // R8: a waiting word is held until taken
  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && !pcm_ready) |=> pcm_valid);

  // R8: a waiting word does not change unless replaced
  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && !pcm_ready && !load) |=> ($stable(pcm_data) && $stable(pcm_right)));

  // R9: a load, even while the old word is accepted, leaves a word valid
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pcm_valid);

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SAMPLE_W   = 20,
  parameter int SYNC_DEPTH = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_clk,
  input  logic                chan_sel,
  input  logic                ser_data,
  input  logic [2:0]          frame_fmt,
  output logic [SAMPLE_W-1:0] pcm_data,
  output logic                pcm_right,
  output logic                pcm_valid,
  input  logic                pcm_ready
);
  logic                rise, ws, sd;
  logic                word_done;
  logic [SAMPLE_W-1:0] word;
  logic                word_right;

  aud_rx_tap #(.SYNC_DEPTH(SYNC_DEPTH)) u_tap (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_clk  (bit_clk),
    .chan_sel (chan_sel),
    .ser_data (ser_data),
    .rise     (rise),
    .ws       (ws),
    .sd       (sd)
  );

  aud_rx_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt        (frame_fmt),
    .rise       (rise),
    .ws         (ws),
    .sd         (sd),
    .done       (word_done),
    .word       (word),
    .word_right (word_right)
  );

  aud_rx_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (word_done),
    .load_data  (word),
    .load_right (word_right),
    .pcm_data   (pcm_data),
    .pcm_right  (pcm_right),
    .pcm_valid  (pcm_valid),
    .pcm_ready  (pcm_ready)
  );

  // R8: the output only becomes valid because a word was finished
  assert_valid_from_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_valid) |-> $past(word_done));

endmodule

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_clk = 1'b0;
  logic        chan_sel = 1'b0;
  logic        ser_data = 1'b0;
  logic [2:0]  frame_fmt = 3'd4;
  logic [19:0] pcm_data;
  logic        pcm_right;
  logic        pcm_valid;
  logic        pcm_ready = 1'b1;

  always #4 clk = ~clk;

  aud_serial_rx dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_clk   (bit_clk),
    .chan_sel  (chan_sel),
    .ser_data  (ser_data),
    .frame_fmt (frame_fmt),
    .pcm_data  (pcm_data),
    .pcm_right (pcm_right),
    .pcm_valid (pcm_valid),
    .pcm_ready (pcm_ready)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int          rx_total = 0;
  logic [19:0] rx_data [64];
  logic        rx_right [64];
  logic        prev_b = 1'b0;

  // fields: fmt[55:53] len[52:48] left[47:24] right[23:0]
  localparam logic [55:0] VEC [8] = '{
    {3'd4, 5'd20, 24'h012345, 24'h0ABCDE},
    {3'd4, 5'd16, 24'h00BEEF, 24'h001234},
    {3'd4, 5'd24, 24'hA5A5FF, 24'h00000F},
    {3'd0, 5'd20, 24'h080001, 24'h07FFFE},
    {3'd0, 5'd18, 24'h02AAAA, 24'h015555},
    {3'd1, 5'd16, 24'h008001, 24'h007FFF},
    {3'd2, 5'd18, 24'h020000, 24'h01FFFF},
    {3'd3, 5'd20, 24'h0FEDCB, 24'h001234}
  };

  // monitor: sample between the drive at the falling edge and the next rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && pcm_valid && pcm_ready) begin
      if (rx_total < 64) begin
        rx_data[rx_total]  = pcm_data;
        rx_right[rx_total] = pcm_right;
      end
      rx_total++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] expect_word(input logic [2:0] f, input int w, input logic [23:0] s);
    logic [19:0] r;
    if (f >= 3'd1 && f <= 3'd3) begin
      for (int i = 0; i < 20; i++) r[i] = (i < w) ? s[i] : s[w-1];
    end else if (w >= 20) begin
      r = 20'(s >> (w - 20));
    end else begin
      r = 20'(s << (20 - w));
    end
    return r;
  endfunction

  function automatic logic gen_bit(input logic [2:0] f, input int w, input logic [23:0] s, input int i);
    if (f >= 3'd1 && f <= 3'd3) return (i >= 32 - w) ? s[31-i] : 1'b1;
    return (i < w) ? s[w-1-i] : 1'b0;
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    if (f == 3'd0) return "R3";
    if (f == 3'd4) return "R2";
    return "R4";
  endfunction

  task automatic send_bit(input logic ws, input logic d, input bit pulse);
    @(negedge clk); bit_clk = 1'b0; chan_sel = ws; ser_data = d;
    @(negedge clk);
    @(negedge clk); bit_clk = 1'b1;
    @(negedge clk);
    if (pulse) begin
      @(negedge clk); pcm_ready = 1'b1;
      @(negedge clk); pcm_ready = 1'b0;
    end
  endtask

  task automatic put(input logic [2:0] f, input logic ws, input logic d, input bit pulse);
    logic o;
    o = (f == 3'd0) ? prev_b : d;
    prev_b = d;
    send_bit(ws, o, pulse);
  endtask

  task automatic send_chan(input logic [2:0] f, input int w, input logic ws, input logic [23:0] s);
    for (int i = 0; i < 32; i++) put(f, ws, gen_bit(f, w, s, i), 1'b0);
  endtask

  task automatic lead(input logic [2:0] f);
    prev_b = 1'b0;
    for (int i = 0; i < 4; i++) put(f, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic trail(input logic [2:0] f);
    for (int i = 0; i < 4; i++) put(f, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_clk = 1'b0; chan_sel = 1'b0; ser_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [19:0] held;

    // R1: reset state
    do_reset();
    #1;
    chk(pcm_valid == 1'b0, "R1", 32'(pcm_valid), 32'h0);
    chk(pcm_data == 20'h0, "R1", 32'(pcm_data), 32'h0);
    chk(pcm_right == 1'b0, "R1", 32'(pcm_right), 32'h0);

    // table of framings: R2, R3, R4 data; R5 order and channel tags
    for (int v = 0; v < 8; v++) begin
      logic [2:0]  f;
      int          w;
      logic [23:0] l, r;
      f = VEC[v][55:53];
      w = int'(VEC[v][52:48]);
      l = VEC[v][47:24];
      r = VEC[v][23:0];
      do_reset();
      frame_fmt = f;
      pcm_ready = 1'b1;
      base = rx_total;
      lead(f);
      send_chan(f, w, 1'b0, l);
      send_chan(f, w, 1'b1, r);
      trail(f);
      settle();
      chk(rx_total == base + 2, "R5", 32'(rx_total - base), 32'd2);
      chk(rx_data[base] == expect_word(f, w, l), tag_of(f), 32'(rx_data[base]), 32'(expect_word(f, w, l)));
      chk(rx_right[base] == 1'b0, "R5", 32'(rx_right[base]), 32'h0);
      chk(rx_data[base+1] == expect_word(f, w, r), tag_of(f), 32'(rx_data[base+1]), 32'(expect_word(f, w, r)));
      chk(rx_right[base+1] == 1'b1, "R5", 32'(rx_right[base+1]), 32'h1);
    end

    // R1: reset after traffic clears the outputs
    do_reset();
    #1;
    chk(pcm_data == 20'h0 && pcm_valid == 1'b0, "R1", 32'(pcm_data), 32'h0);

    // R6: a left period cut by reset is not issued, the following right one is
    do_reset();
    frame_fmt = 3'd4;
    base = rx_total;
    prev_b = 1'b0;
    for (int i = 0; i < 4; i++) put(3'd4, 1'b0, 1'b1, 1'b0);
    send_chan(3'd4, 20, 1'b1, 24'h013579);
    trail(3'd4);
    settle();
    chk(rx_total == base + 1, "R6", 32'(rx_total - base), 32'd1);
    chk(rx_data[base] == 20'h13579 && rx_right[base] == 1'b1, "R6", 32'(rx_data[base]), 32'h13579);

    // R6: the period open across a format change is dropped
    @(negedge clk); frame_fmt = 3'd1;
    base = rx_total;
    send_chan(3'd1, 16, 1'b1, 24'h008421);
    trail(3'd1);
    settle();
    chk(rx_total == base + 1, "R6", 32'(rx_total - base), 32'd1);
    chk(rx_data[base] == 20'hF8421, "R4", 32'(rx_data[base]), 32'hF8421);

    // R7: reserved codes issue nothing and freeze the outputs
    held = pcm_data;
    base = rx_total;
    for (int c = 5; c < 8; c++) begin
      @(negedge clk); frame_fmt = 3'(c);
      lead(3'(c));
      send_chan(3'(c), 20, 1'b0, 24'h0CAFE1);
      send_chan(3'(c), 20, 1'b1, 24'h0BEAD2);
      trail(3'(c));
      settle();
    end
    #1;
    chk(rx_total == base, "R7", 32'(rx_total - base), 32'd0);
    chk(pcm_data == held && pcm_valid == 1'b0, "R7", 32'(pcm_data), 32'(held));

    // R8: back-pressure holds the waiting word; the newer word replaces it
    do_reset();
    frame_fmt = 3'd4;
    pcm_ready = 1'b0;
    base = rx_total;
    lead(3'd4);
    send_chan(3'd4, 20, 1'b0, 24'h011111);
    send_chan(3'd4, 20, 1'b1, 24'h022222);
    #1;
    chk(pcm_valid == 1'b1 && pcm_data == 20'h11111, "R8", 32'(pcm_data), 32'h11111);
    trail(3'd4);
    settle();
    #1;
    chk(pcm_valid == 1'b1 && pcm_data == 20'h22222 && pcm_right == 1'b1, "R8", 32'(pcm_data), 32'h22222);
    chk(rx_total == base, "R8", 32'(rx_total - base), 32'd0);
    @(negedge clk); pcm_ready = 1'b1;
    settle();
    chk(rx_total == base + 1 && rx_data[base] == 20'h22222, "R8", 32'(rx_data[base]), 32'h22222);

    // R9: acceptance of the waiting word in the cycle the next word loads
    do_reset();
    frame_fmt = 3'd4;
    pcm_ready = 1'b0;
    base = rx_total;
    lead(3'd4);
    send_chan(3'd4, 20, 1'b0, 24'h00ABCD);
    send_chan(3'd4, 20, 1'b1, 24'h054321);
    put(3'd4, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) put(3'd4, 1'b0, 1'b0, 1'b0);
    settle();
    #1;
    chk(rx_total == base + 1 && rx_data[base] == 20'h0ABCD, "R9", 32'(rx_data[base]), 32'h0ABCD);
    chk(pcm_valid == 1'b1 && pcm_data == 20'h54321, "R9", 32'(pcm_data), 32'h54321);
    @(negedge clk); pcm_ready = 1'b1;
    settle();
    chk(rx_total == base + 2 && rx_data[base+1] == 20'h54321 && rx_right[base+1] == 1'b1,
        "R9", 32'(rx_data[base+1]), 32'h54321);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule